// File: doc/BRIEF.md
# Default Control Pipe Stage Sequencer

This block tracks control transfers on the default pipe of a USB device. It sits between the packet-level token interface of the serial engine and the firmware. The token interface delivers SETUP, IN and OUT events, each with a payload length and, for OUT data, the data toggle the host used. The block answers every IN or OUT token with a handshake code: data, ACK, NAK or STALL. It also answers every SETUP with ACK. It raises a one-cycle interrupt whenever firmware has something to handle. Packet storage sits outside the block, so each packet appears here only as a byte count.

Firmware moves the transfer through its stages with single-cycle write strobes. One strobe arms a packet to send, together with its length. One strobe releases a received packet. A data-end strobe marks the last packet. Two more strobes request a stall and acknowledge a stall that has been reported. A SETUP token always restarts the pipe. After a SETUP, firmware chooses the direction: it releases the setup packet with the receive flag to enter the receive stage, or it arms a packet to enter the transmit stage. When a data packet is shorter than 32 bytes (a zero-length packet included), the Data stage ends. The Status stage then runs in the opposite direction. If a firmware write and a token arrive in the same cycle, the token is handled and the write is dropped.

Top module: `ctl_ep_ctrl`

## Requirements
- R1: After reset, the stage is IDLE (0), no handshake or interrupt is output, and every firmware-visible flag is 0.
- R2: A SETUP token (tok_kind 1) is answered with ACK (hs_code 1) in any stage. It raises irq, sets out_rdy and setup_pend, loads rx_count with the token length, clears in_rdy and send_stall, and returns the stage to IDLE.
- R3: In IDLE, an IN (tok_kind 2) or OUT (tok_kind 3) token is answered with NAK (hs_code 2). In TX (stage 1), an IN token that arrives while in_rdy is 0 is answered with NAK.
- R4: In TX, an IN token that arrives while in_rdy is 1 is answered with a data handshake (hs_code 0) carrying the armed length on hs_len. The same packet clears in_rdy and raises irq, so each packet sent gives one interrupt.
- R5: The first Data-stage packet after a SETUP uses DATA1 (hs_pid 1), and the toggle alternates on each packet that is sent or accepted. The zero-length status packet the device sends is always DATA1.
- R6: In RX (stage 2), an OUT token that arrives while out_rdy is 0 and carries the expected toggle is answered with ACK. It sets out_rdy, loads rx_count and raises irq. While out_rdy is 1 an OUT token gets NAK, and an IN token in RX gets NAK.
- R7: An OUT packet that repeats the previous toggle is answered with ACK but discarded: out_rdy, rx_count and irq stay unchanged.
- R8: rx_short is 1 exactly when out_rdy is 1 and rx_count is below 32, which marks the last packet of a received Data stage.
- R9: When an armed packet was written with data-end, the stage moves to STATUS-OUT (3) once that packet is sent. There, a zero-length OUT is answered with ACK and the stage returns to IDLE.
- R10: A release strobe with data-end, in IDLE or RX, moves the stage to STATUS-IN (4). There, an IN token gets a zero-length DATA1 packet and the stage returns to IDLE.
- R11: In STATUS-OUT, an OUT token with a nonzero length is answered with STALL (hs_code 3). It sets sent_stall, raises irq and returns the stage to IDLE.
- R12: While send_stall is 1, the next IN or OUT token is answered with STALL. That token sets sent_stall, clears send_stall, raises irq and returns the stage to IDLE.
- R13: While sent_stall is 1, every IN or OUT token is answered with STALL and no interrupt is raised. Only the firmware clear strobe resets sent_stall.
- R14: An OUT token whose length exceeds 32 bytes is answered with STALL in any stage. It sets sent_stall, raises irq and returns the stage to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 1 SETUP, 2 IN, 3 OUT |
| tok_len | input | LEN_W | Payload length of SETUP/OUT data |
| tok_pid | input | 1 | Toggle of host data (1 = DATA1) |
| fw_wr | input | 1 | Firmware write strobe |
| fw_in_rdy | input | 1 | Arm a packet to send |
| fw_in_len | input | LEN_W | Length of the armed packet |
| fw_clr_out | input | 1 | Release the received packet |
| fw_to_rx | input | 1 | With release in IDLE: enter RX |
| fw_data_end | input | 1 | Last packet marker |
| fw_send_stall | input | 1 | Request a stall |
| fw_clr_sent_stall | input | 1 | Clear the sent-stall flag |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 STALL |
| hs_pid | output | 1 | Toggle of the device data packet |
| hs_len | output | LEN_W | Length of the device data packet |
| irq | output | 1 | One-cycle interrupt pulse |
| out_rdy | output | 1 | Received packet waiting |
| in_rdy | output | 1 | Armed packet pending |
| sent_stall | output | 1 | A stall was sent |
| send_stall | output | 1 | Stall request pending |
| rx_count | output | LEN_W | Byte count of the received packet |
| rx_short | output | 1 | Received packet is shorter than maximum |
| setup_pend | output | 1 | Unreleased setup packet |
| stage | output | 3 | 0 IDLE, 1 TX, 2 RX, 3 STATUS-OUT, 4 STATUS-IN |

## Verification
The bench drives complete transmit and receive transfers. These include a full 32-byte packet followed by a short or zero-length one, so a sequencer that ends the stage on the wrong length, or leaves the toggle unflipped, would send the wrong PID or stall in the wrong stage. A repeated toggle on an OUT packet is checked: a design that does not filter it would raise a second interrupt and overwrite the byte count. The stall paths are each exercised: a nonzero status packet, a pending stall request, an oversize OUT, and tokens that arrive while the stall flag is still set. A design that cleared the flag by itself, or raised an interrupt on every stalled token, would be caught. A SETUP that arrives in the middle of a transmit is also checked, because a design that did not abort would keep the stale armed packet.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam logic [1:0] TK_SETUP = 2'd1;
  localparam logic [1:0] TK_IN    = 2'd2;
  localparam logic [1:0] TK_OUT   = 2'd3;

  localparam logic [1:0] HS_DATA  = 2'd0;
  localparam logic [1:0] HS_ACK   = 2'd1;
  localparam logic [1:0] HS_NAK   = 2'd2;
  localparam logic [1:0] HS_STALL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TX   = 3'd1,
    ST_RX   = 3'd2,
    ST_SOUT = 3'd3,
    ST_SIN  = 3'd4
  } stage_e;
endpackage

// File: rtl/ctl_ep_toggle.sv
module ctl_ep_toggle (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic flip,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst || init) tog <= 1'b1;
    else if (flip)   tog <= ~tog;
  end
endmodule

// File: rtl/ctl_ep_csr.sv
module ctl_ep_csr #(
  parameter int MAX_PKT = 32,
  localparam int LEN_W = $clog2(MAX_PKT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fw_en,
  input  logic             fw_in_rdy,
  input  logic [LEN_W-1:0] fw_in_len,
  input  logic             fw_clr_out,
  input  logic             fw_data_end,
  input  logic             fw_send_stall,
  input  logic             fw_clr_sent_stall,
  input  logic             ev_setup,
  input  logic             ev_rx,
  input  logic             ev_sent,
  input  logic             ev_stall,
  input  logic [LEN_W-1:0] tok_len,
  output logic             in_rdy,
  output logic             in_end,
  output logic [LEN_W-1:0] in_len,
  output logic             out_rdy,
  output logic [LEN_W-1:0] rx_count,
  output logic             setup_pend,
  output logic             send_stall,
  output logic             sent_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_rdy     <= 1'b0;
      in_end     <= 1'b0;
      in_len     <= '0;
      out_rdy    <= 1'b0;
      rx_count   <= '0;
      setup_pend <= 1'b0;
      send_stall <= 1'b0;
      sent_stall <= 1'b0;
    end else begin
      if (ev_setup) begin
        in_rdy     <= 1'b0;
        in_end     <= 1'b0;
        out_rdy    <= 1'b1;
        rx_count   <= tok_len;
        setup_pend <= 1'b1;
        send_stall <= 1'b0;
      end else begin
        if (ev_rx) begin
          out_rdy  <= 1'b1;
          rx_count <= tok_len;
        end
        if (ev_sent) in_rdy <= 1'b0;
        if (ev_stall) begin
          sent_stall <= 1'b1;
          send_stall <= 1'b0;
        end
        if (fw_en) begin
          if (fw_in_rdy) begin
            in_rdy <= 1'b1;
            in_end <= fw_data_end;
            in_len <= fw_in_len;
          end
          if (fw_clr_out) begin
            out_rdy    <= 1'b0;
            setup_pend <= 1'b0;
          end
          if (fw_send_stall)     send_stall <= 1'b1;
          if (fw_clr_sent_stall) sent_stall <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter int MAX_PKT = 32,
  localparam int LEN_W = $clog2(MAX_PKT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [LEN_W-1:0] tok_len,
  input  logic             tok_pid,
  input  logic             fw_en,
  input  logic             fw_in_rdy,
  input  logic             fw_clr_out,
  input  logic             fw_to_rx,
  input  logic             fw_data_end,
  input  logic             in_rdy,
  input  logic             in_end,
  input  logic [LEN_W-1:0] in_len,
  input  logic             out_rdy,
  input  logic             send_stall,
  input  logic             sent_stall,
  input  logic             tog,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             hs_pid,
  output logic [LEN_W-1:0] hs_len,
  output logic             irq,
  output logic [2:0]       stage,
  output logic             ev_setup,
  output logic             ev_rx,
  output logic             ev_sent,
  output logic             ev_stall,
  output logic             tog_init,
  output logic             tog_flip
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

  stage_e           st, st_n;
  logic             hv_n, pid_n, irq_n;
  logic [1:0]       code_n;
  logic [LEN_W-1:0] len_n;
  logic             is_in, is_out;

  assign is_in  = tok_valid && tok_kind == TK_IN;
  assign is_out = tok_valid && tok_kind == TK_OUT;

  always_comb begin
    st_n     = st;
    hv_n     = 1'b0;
    code_n   = HS_ACK;
    pid_n    = 1'b0;
    len_n    = '0;
    irq_n    = 1'b0;
    ev_setup = 1'b0;
    ev_rx    = 1'b0;
    ev_sent  = 1'b0;
    ev_stall = 1'b0;
    tog_init = 1'b0;
    tog_flip = 1'b0;
    if (tok_valid && tok_kind == TK_SETUP) begin
      hv_n     = 1'b1;
      irq_n    = 1'b1;
      ev_setup = 1'b1;
      tog_init = 1'b1;
      st_n     = ST_IDLE;
    end else if (is_in || is_out) begin
      hv_n = 1'b1;
      if (sent_stall) begin
        code_n = HS_STALL;
      end else if (send_stall || (is_out && tok_len > MAX_LEN)) begin
        code_n   = HS_STALL;
        ev_stall = 1'b1;
        irq_n    = 1'b1;
        st_n     = ST_IDLE;
      end else begin
        code_n = HS_NAK;
        unique case (st)
          ST_TX: if (is_in && in_rdy) begin
            code_n   = HS_DATA;
            pid_n    = tog;
            len_n    = in_len;
            ev_sent  = 1'b1;
            irq_n    = 1'b1;
            tog_flip = 1'b1;
            if (in_end) st_n = ST_SOUT;
          end
          ST_RX: if (is_out && !out_rdy) begin
            code_n = HS_ACK;
            if (tok_pid == tog) begin
              ev_rx    = 1'b1;
              irq_n    = 1'b1;
              tog_flip = 1'b1;
            end
          end
          ST_SOUT: if (is_out) begin
            st_n = ST_IDLE;
            if (tok_len == '0) begin
              code_n = HS_ACK;
            end else begin
              code_n   = HS_STALL;
              ev_stall = 1'b1;
              irq_n    = 1'b1;
            end
          end
          ST_SIN: if (is_in) begin
            code_n = HS_DATA;
            pid_n  = 1'b1;
            st_n   = ST_IDLE;
          end
          default: ;
        endcase
      end
    end else if (fw_en) begin
      if (st == ST_IDLE) begin
        if (fw_clr_out && out_rdy) begin
          if (fw_data_end)   st_n = ST_SIN;
          else if (fw_to_rx) st_n = ST_RX;
        end else if (fw_in_rdy) begin
          st_n = ST_TX;
        end
      end else if (st == ST_RX && fw_clr_out && out_rdy && fw_data_end) begin
        st_n = ST_SIN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
      hs_pid   <= 1'b0;
      hs_len   <= '0;
      irq      <= 1'b0;
    end else begin
      st       <= st_n;
      hs_valid <= hv_n;
      hs_code  <= code_n;
      hs_pid   <= pid_n;
      hs_len   <= len_n;
      irq      <= irq_n;
    end
  end

  assign stage = st;
endmodule

// File: rtl/ctl_ep_ctrl.sv
module ctl_ep_ctrl #(
  parameter int MAX_PKT = 32,
  localparam int LEN_W = $clog2(MAX_PKT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [LEN_W-1:0] tok_len,
  input  logic             tok_pid,
  input  logic             fw_wr,
  input  logic             fw_in_rdy,
  input  logic [LEN_W-1:0] fw_in_len,
  input  logic             fw_clr_out,
  input  logic             fw_to_rx,
  input  logic             fw_data_end,
  input  logic             fw_send_stall,
  input  logic             fw_clr_sent_stall,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             hs_pid,
  output logic [LEN_W-1:0] hs_len,
  output logic             irq,
  output logic             out_rdy,
  output logic             in_rdy,
  output logic             sent_stall,
  output logic             send_stall,
  output logic [LEN_W-1:0] rx_count,
  output logic             rx_short,
  output logic             setup_pend,
  output logic [2:0]       stage
);
  logic             fw_en, in_end, tog;
  logic             ev_setup, ev_rx, ev_sent, ev_stall, tog_init, tog_flip;
  logic [LEN_W-1:0] in_len;

  assign fw_en = fw_wr && !tok_valid;

  ctl_ep_csr #(.MAX_PKT(MAX_PKT)) csr_i (
    .clk(clk), .rst(rst), .fw_en(fw_en),
    .fw_in_rdy(fw_in_rdy), .fw_in_len(fw_in_len), .fw_clr_out(fw_clr_out),
    .fw_data_end(fw_data_end), .fw_send_stall(fw_send_stall),
    .fw_clr_sent_stall(fw_clr_sent_stall),
    .ev_setup(ev_setup), .ev_rx(ev_rx), .ev_sent(ev_sent), .ev_stall(ev_stall),
    .tok_len(tok_len), .in_rdy(in_rdy), .in_end(in_end), .in_len(in_len),
    .out_rdy(out_rdy), .rx_count(rx_count), .setup_pend(setup_pend),
    .send_stall(send_stall), .sent_stall(sent_stall)
  );

  ctl_ep_toggle tog_i (
    .clk(clk), .rst(rst), .init(tog_init), .flip(tog_flip), .tog(tog)
  );

  ctl_ep_seq #(.MAX_PKT(MAX_PKT)) seq_i (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_len(tok_len), .tok_pid(tok_pid), .fw_en(fw_en),
    .fw_in_rdy(fw_in_rdy), .fw_clr_out(fw_clr_out), .fw_to_rx(fw_to_rx),
    .fw_data_end(fw_data_end), .in_rdy(in_rdy), .in_end(in_end),
    .in_len(in_len), .out_rdy(out_rdy), .send_stall(send_stall),
    .sent_stall(sent_stall), .tog(tog), .hs_valid(hs_valid),
    .hs_code(hs_code), .hs_pid(hs_pid), .hs_len(hs_len), .irq(irq),
    .stage(stage), .ev_setup(ev_setup), .ev_rx(ev_rx), .ev_sent(ev_sent),
    .ev_stall(ev_stall), .tog_init(tog_init), .tog_flip(tog_flip)
  );

  assign rx_short = out_rdy && (rx_count < LEN_W'(MAX_PKT));
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk (
  input logic       clk,
  input logic       rst,
  input logic       tok_valid,
  input logic [1:0] tok_kind,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       irq,
  input logic       out_rdy,
  input logic       in_rdy,
  input logic       setup_pend,
  input logic       send_stall,
  input logic       sent_stall,
  input logic [2:0] stage
);
  // R2
  setup_load_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid && tok_kind == 2'd1 |=> hs_valid && hs_code == 2'd1 && out_rdy
      && setup_pend && !in_rdy && stage == 3'd0);

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sent_stall && tok_valid && tok_kind != 2'd1 && tok_kind != 2'd0
      |=> hs_valid && hs_code == 2'd3 && !irq && sent_stall);

  // R4
  irq_with_hs_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> hs_valid);

  // R6
  rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_rdy) |-> irq);

  // R3
  tx_nak_chk: assert property (@(posedge clk) disable iff (rst)
    stage == 3'd1 && !in_rdy && !send_stall && !sent_stall
      && tok_valid && tok_kind == 2'd2 |=> hs_valid && hs_code == 2'd2);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> stage == 3'd0 && !hs_valid && !irq);
endmodule

bind ctl_ep_ctrl ctl_ep_chk chk_i (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
  .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq), .out_rdy(out_rdy),
  .in_rdy(in_rdy), .setup_pend(setup_pend), .send_stall(send_stall),
  .sent_stall(sent_stall), .stage(stage)
);

// File: tb/ctl_ep_ctrl_test.sv
module ctl_ep_ctrl_test;
  localparam int LW = 6;
  logic clk = 0, rst = 1;
  logic tok_valid = 0, tok_pid = 0;
  logic [1:0] tok_kind = 0;
  logic [LW-1:0] tok_len = 0, fw_in_len = 0;
  logic fw_wr = 0, fw_in_rdy = 0, fw_clr_out = 0, fw_to_rx = 0;
  logic fw_data_end = 0, fw_send_stall = 0, fw_clr_sent_stall = 0;
  logic hs_valid, hs_pid, irq, out_rdy, in_rdy, sent_stall, send_stall;
  logic rx_short, setup_pend;
  logic [1:0] hs_code;
  logic [LW-1:0] hs_len, rx_count;
  logic [2:0] stage;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_ep_ctrl uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tok(input logic [1:0] k, input int len, input logic pid);
    @(negedge clk);
    tok_valid = 1; tok_kind = k; tok_len = LW'(len); tok_pid = pid;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic fw(input bit ir, input int ln, input bit clr, input bit rx,
                    input bit de, input bit ss, input bit cs);
    @(negedge clk);
    fw_wr = 1; fw_in_rdy = ir; fw_in_len = LW'(ln); fw_clr_out = clr;
    fw_to_rx = rx; fw_data_end = de; fw_send_stall = ss; fw_clr_sent_stall = cs;
    @(negedge clk);
    fw_wr = 0; fw_in_rdy = 0; fw_clr_out = 0; fw_to_rx = 0;
    fw_data_end = 0; fw_send_stall = 0; fw_clr_sent_stall = 0;
  endtask

  task automatic hs(string tag, int code, int pid, int len, int ir);
    chk({tag, " valid"}, hs_valid, 1);
    chk({tag, " code"}, hs_code, code);
    if (code == 0) begin
      chk({tag, " pid"}, hs_pid, pid);
      chk({tag, " len"}, hs_len, len);
    end
    chk({tag, " irq"}, irq, ir);
  endtask

  task automatic t_reset();
    chk("R1 stage", stage, 0);
    chk("R1 hs", hs_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {out_rdy, in_rdy, sent_stall, send_stall, setup_pend, rx_short}, 0);
  endtask

  task automatic t_tx();
    tok(1, 8, 0);
    hs("R2 setup", 1, 0, 0, 1);
    chk("R2 out_rdy", out_rdy, 1); chk("R2 count", rx_count, 8);
    chk("R2 pend", setup_pend, 1); chk("R2 stage", stage, 0);
    fw(0, 0, 1, 0, 0, 0, 0);
    chk("R2 released", setup_pend, 0);
    tok(2, 0, 0); hs("R3 idle IN", 2, 0, 0, 0);
    fw(1, 32, 0, 0, 0, 0, 0);
    chk("R4 stage TX", stage, 1); chk("R4 in_rdy", in_rdy, 1);
    tok(2, 0, 0); hs("R4 R5 first IN", 0, 1, 32, 1);
    chk("R4 in_rdy clr", in_rdy, 0);
    tok(2, 0, 0); hs("R3 TX NAK", 2, 0, 0, 0);
    fw(1, 5, 0, 0, 1, 0, 0);
    tok(2, 0, 0); hs("R5 second IN", 0, 0, 5, 1);
    chk("R9 stage SOUT", stage, 3);
    tok(3, 0, 1); hs("R9 status ACK", 1, 0, 0, 0);
    chk("R9 idle", stage, 0);
  endtask

  task automatic t_rx();
    tok(1, 8, 0);
    fw(0, 0, 1, 1, 0, 0, 0);
    chk("R6 stage RX", stage, 2);
    tok(2, 0, 0); hs("R6 IN in RX", 2, 0, 0, 0);
    tok(3, 32, 1); hs("R6 OUT ACK", 1, 0, 0, 1);
    chk("R6 out_rdy", out_rdy, 1); chk("R6 count", rx_count, 32);
    chk("R8 full not short", rx_short, 0);
    tok(3, 4, 0); hs("R6 busy NAK", 2, 0, 0, 0);
    chk("R6 count kept", rx_count, 32);
    fw(0, 0, 1, 0, 0, 0, 0);
    tok(3, 7, 1); hs("R7 repeat ACK", 1, 0, 0, 0);
    chk("R7 discarded", out_rdy, 0);
    tok(3, 0, 0); hs("R7 R5 next toggle", 1, 0, 0, 1);
    chk("R8 zlp count", rx_count, 0); chk("R8 short", rx_short, 1);
    fw(0, 0, 1, 0, 1, 0, 0);
    chk("R10 stage SIN", stage, 4);
    tok(2, 0, 0); hs("R10 R5 status ZLP", 0, 1, 0, 0);
    chk("R10 idle", stage, 0);
  endtask

  task automatic t_status_fail();
    tok(1, 8, 0);
    fw(0, 0, 1, 0, 0, 0, 0);
    fw(1, 4, 0, 0, 1, 0, 0);
    tok(2, 0, 0); hs("R9 last IN", 0, 1, 4, 1);
    tok(3, 3, 1); hs("R11 status STALL", 3, 0, 0, 1);
    chk("R11 sent_stall", sent_stall, 1); chk("R11 idle", stage, 0);
    tok(2, 0, 0); hs("R13 held STALL", 3, 0, 0, 0);
    tok(3, 0, 0); hs("R13 held OUT STALL", 3, 0, 0, 0);
    chk("R13 still set", sent_stall, 1);
    fw(0, 0, 0, 0, 0, 0, 1);
    chk("R13 cleared", sent_stall, 0);
    tok(2, 0, 0); hs("R13 after clear NAK", 2, 0, 0, 0);
  endtask

  task automatic t_send_stall();
    tok(1, 8, 0);
    fw(0, 0, 1, 1, 0, 0, 0);
    fw(0, 0, 0, 0, 0, 1, 0);
    chk("R12 send_stall", send_stall, 1);
    tok(3, 2, 1); hs("R12 STALL", 3, 0, 0, 1);
    chk("R12 sent", sent_stall, 1); chk("R12 req clr", send_stall, 0);
    chk("R12 idle", stage, 0); chk("R12 no data", out_rdy, 0);
    fw(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_oversize();
    tok(1, 8, 0);
    fw(0, 0, 1, 1, 0, 0, 0);
    tok(3, 40, 1); hs("R14 oversize STALL", 3, 0, 0, 1);
    chk("R14 sent", sent_stall, 1); chk("R14 idle", stage, 0);
    chk("R14 no data", out_rdy, 0);
    fw(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_abort();
    tok(1, 8, 0);
    fw(0, 0, 1, 0, 0, 0, 0);
    fw(1, 8, 0, 0, 0, 0, 0);
    chk("R2 pre TX", stage, 1);
    tok(1, 8, 0); hs("R2 abort", 1, 0, 0, 1);
    chk("R2 abort stage", stage, 0); chk("R2 abort in_rdy", in_rdy, 0);
    chk("R2 abort pend", setup_pend, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_status_fail();
    t_send_stall();
    t_oversize();
    t_abort();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule